// File: doc/BRIEF.md
# Select-Coded Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit of configurable width. A three-bit select and a carry-in choose the operation. When the top select bit is clear, operand A always goes through an adder. The other select bits pick the adder's second input from four sources: zero, B, the bitwise complement of B, or all ones. The carry-in is added at the least significant position. Together these give eight arithmetic variants, among them increment, decrement, add with carry and subtract with borrow.

When the top select bit is set, the block instead produces one of four bitwise functions of the operands. In this mode the carry-in has no effect and the carry-out is held low. The block has no internal state. A surrounding datapath registers the result and the carry-out wherever it needs them.

Top module: `selAlu`

## Requirements
- R1: Select 3'b000 yields A plus carry-in (A when carry-in is 0, A+1 when it is 1), modulo 2^WIDTH.
- R2: Select 3'b001 yields A+B plus carry-in, modulo 2^WIDTH.
- R3: Select 3'b010 yields A+~B plus carry-in, i.e. A−B−1 with carry-in 0 and A−B with carry-in 1, modulo 2^WIDTH.
- R4: Select 3'b011 yields A plus all ones plus carry-in, i.e. A−1 with carry-in 0 and A with carry-in 1, modulo 2^WIDTH.
- R5: Select 3'b100 yields the bitwise OR of A and B.
- R6: Select 3'b101 yields the bitwise XOR of A and B.
- R7: Select 3'b110 yields the bitwise AND of A and B.
- R8: Select 3'b111 yields the bitwise complement of A.
- R9: For every select with bit 2 set, carryOut is 0 and the result does not depend on carryIn.
- R10: For every select with bit 2 clear, carryOut equals bit WIDTH of the full-width sum of A, the chosen second operand and carryIn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aIn | input | WIDTH | First operand, always the adder's first input |
| bIn | input | WIDTH | Second operand source |
| sel | input | 3 | Operation select; bit 2 picks logic mode |
| carryIn | input | 1 | Carry into the least significant adder bit |
| result | output | WIDTH | Operation result |
| carryOut | output | 1 | Adder carry out; 0 in logic mode |

## Verification
The checker assumes that all inputs carry known 0/1 values. It skips evaluation while the select is unknown, so it does not trip before the bench first drives the inputs. The bench drives every input from a single place, half a clock period away from the sampling point, so that each input vector has settled before it is compared. The sweep runs a four-bit instance through every combination of select, carry-in and both operands. This covers carry propagation from bit 0 to the top, wrap-around at zero and at all ones, and the indifference of the logic modes to the carry-in.

// File: rtl/selAluPkg.sv
package selAluPkg;

  typedef enum logic [1:0] {
    LF_OR  = 2'b00,
    LF_XOR = 2'b01,
    LF_AND = 2'b10,
    LF_NOTA = 2'b11
  } logicFn_t;

  // Strobes from the select decoder to the datapath.
  typedef struct packed {
    logic     logicMode;
    logic     opndB;
    logic     opndInvB;
    logic     opndOnes;
    logicFn_t logicFn;
  } aluCtrl_t;

endpackage

// File: rtl/selAluCtrl.sv
module selAluCtrl
  import selAluPkg::*;
(
  input  logic [2:0] sel,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl           = '0;
    ctrl.logicMode = sel[2];
    ctrl.logicFn   = logicFn_t'(sel[1:0]);
    if (!sel[2]) begin
      unique case (sel[1:0])
        2'b00:   ; // zero operand: no strobe set
        2'b01:   ctrl.opndB    = 1'b1;
        2'b10:   ctrl.opndInvB = 1'b1;
        default: ctrl.opndOnes = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/selAluDatapath.sv
module selAluDatapath
  import selAluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             carryIn,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  logic [WIDTH-1:0] opnd;
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH:0]   carryChain;
  logic [WIDTH-1:0] logicOut;

  // Second adder operand: masked sources ORed together (strobes one-hot or none).
  assign opnd = ({WIDTH{ctrl.opndB}}    &  bIn)
              | ({WIDTH{ctrl.opndInvB}} & ~bIn)
              | ({WIDTH{ctrl.opndOnes}});

  assign carryChain[0] = carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign sumBits[i]      = aIn[i] ^ opnd[i] ^ carryChain[i];
    assign carryChain[i+1] = (aIn[i] & opnd[i])
                           | (aIn[i] & carryChain[i])
                           | (opnd[i] & carryChain[i]);
  end

  always_comb begin
    unique case (ctrl.logicFn)
      LF_OR:   logicOut = aIn | bIn;
      LF_XOR:  logicOut = aIn ^ bIn;
      LF_AND:  logicOut = aIn & bIn;
      default: logicOut = ~aIn;
    endcase
  end

  assign result   = ctrl.logicMode ? logicOut : sumBits;
  assign carryOut = carryChain[WIDTH] & ~ctrl.logicMode;

endmodule

// File: rtl/selAlu.sv
module selAlu
  import selAluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic [2:0]       sel,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  aluCtrl_t ctrl;

  selAluCtrl u_ctrl (
    .sel  (sel),
    .ctrl (ctrl)
  );

  selAluDatapath #(.WIDTH(WIDTH)) u_dp (
    .aIn      (aIn),
    .bIn      (bIn),
    .carryIn  (carryIn),
    .ctrl     (ctrl),
    .result   (result),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/selAluChk.sv
module selAluChk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] bIn,
  input logic [2:0]       sel,
  input logic             carryIn,
  input logic [WIDTH-1:0] result,
  input logic             carryOut
);

  logic [WIDTH:0] wideA;
  logic [WIDTH:0] wideCin;
  logic [WIDTH:0] sumZero, sumB, sumInvB, sumOnes;

  assign wideA   = {1'b0, aIn};
  assign wideCin = {{WIDTH{1'b0}}, carryIn};
  assign sumZero = wideA + wideCin;
  assign sumB    = wideA + {1'b0, bIn} + wideCin;
  assign sumInvB = wideA + {1'b0, ~bIn} + wideCin;
  assign sumOnes = wideA + {1'b0, {WIDTH{1'b1}}} + wideCin;

  always_comb begin
    if (!$isunknown(sel)) begin
      if (sel == 3'b000) begin
        // R1
        pass_a_chk: assert ({carryOut, result} == sumZero);
      end
      if (sel == 3'b001) begin
        // R2
        add_b_chk: assert ({carryOut, result} == sumB);
      end
      if (sel == 3'b010) begin
        // R3
        sub_b_chk: assert ({carryOut, result} == sumInvB);
      end
      if (sel == 3'b011) begin
        // R4
        dec_a_chk: assert ({carryOut, result} == sumOnes);
      end
      if (sel == 3'b100) begin
        // R5
        or_fn_chk: assert (result == (aIn | bIn));
      end
      if (sel == 3'b101) begin
        // R6
        xor_fn_chk: assert (result == (aIn ^ bIn));
      end
      if (sel == 3'b110) begin
        // R7
        and_fn_chk: assert (result == (aIn & bIn));
      end
      if (sel == 3'b111) begin
        // R8
        not_a_chk: assert (result == ~aIn);
      end
      if (sel[2]) begin
        // R9
        logic_no_carry_chk: assert (carryOut == 1'b0);
      end
    end
  end

endmodule

bind selAlu selAluChk #(.WIDTH(WIDTH)) u_chk (
  .aIn      (aIn),
  .bIn      (bIn),
  .sel      (sel),
  .carryIn  (carryIn),
  .result   (result),
  .carryOut (carryOut)
);

// File: tb/selAlu_tb_top.sv
`timescale 1ns/1ps
module selAlu_tb_top;

  localparam int W    = 4;
  localparam int SPAN = 1 << W;
  localparam int MASK = SPAN - 1;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] aIn, bIn, result;
  logic [2:0]   sel;
  logic         carryIn, carryOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  selAlu #(.WIDTH(W)) dut_i (
    .aIn(aIn), .bIn(bIn), .sel(sel), .carryIn(carryIn),
    .result(result), .carryOut(carryOut)
  );

  function automatic string reqOf(int s);
    case (s)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic checkVal(string req, int act, int exp, int s, int a, int b, int c);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s sel=%0d a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
               req, s, a, b, c, act, exp);
    end
  endtask

  task automatic applyVec(int s, int c, int a, int b);
    int opnd, full, expRes, expCo;
    @(negedge clk);
    sel = 3'(s); carryIn = c[0]; aIn = W'(a); bIn = W'(b);
    #1;
    if (s < 4) begin
      case (s)
        0: opnd = 0;
        1: opnd = b;
        2: opnd = (~b) & MASK;
        default: opnd = MASK;
      endcase
      full   = a + opnd + c;
      expRes = full & MASK;
      expCo  = (full >> W) & 1;
      checkVal(reqOf(s), int'(result), expRes, s, a, b, c);
      checkVal("R10", int'(carryOut), expCo, s, a, b, c);
    end else begin
      case (s)
        4: expRes = a | b;
        5: expRes = a ^ b;
        6: expRes = a & b;
        default: expRes = (~a) & MASK;
      endcase
      // R9: same expected result whichever carry-in is driven
      checkVal((c != 0) ? "R9" : reqOf(s), int'(result), expRes, s, a, b, c);
      checkVal("R9", int'(carryOut), 0, s, a, b, c);
    end
  endtask

  initial begin
    sel = '0; carryIn = 1'b0; aIn = '0; bIn = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Idle state after reset with all-zero inputs: R1 gives 0, no carry
    @(negedge clk); #1;
    checkVal("R1", int'(result), 0, 0, 0, 0, 0);
    checkVal("R10", int'(carryOut), 0, 0, 0, 0, 0);
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < SPAN; a++)
          for (int b = 0; b < SPAN; b++)
            applyVec(s, c, a, b);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule